// File: doc/BRIEF.md
# Interpolating Coarse-Fine Time-to-Digital Controller

This block is the digital core of a multi-channel time-to-digital converter. One shared START event opens a measurement window, and each of several channels waits for its own STOP event. A coarse counter driven by the reference clock counts the clock edges from START to each STOP. Two fine codes are then folded into that count. One comes from an external START interpolator and one from the channel's STOP interpolator. Each fine code gives the time from its event to the next clock edge, in steps of one thousandth of a clock period. The result for each channel is one linear code with a 10 ps LSB when the reference clock runs at 100 MHz.

START and STOP arrive as asynchronous pulses. Each passes through a two-flop synchronizer and a rising-edge detector. The window controller has three states: `WIN_IDLE`, `WIN_OPEN` and `WIN_SHUT`. Any detected START moves it to `WIN_OPEN` and reloads the count. It moves from `WIN_OPEN` to `WIN_SHUT` once the count reaches the full range of 16 edges. Each channel has four states:

- `CH_IDLE` waits for a START.
- `CH_ARMED` moves to `CH_WFINE` on its STOP, or to `CH_HOLD` with the overflow flag set when the window closes first.
- `CH_WFINE` moves to `CH_HOLD` once both fine codes are in.
- `CH_HOLD` returns to `CH_IDLE` on a valid/ready transfer.

A START seen in any channel state moves that channel to `CH_ARMED`. If its STOP is detected in the same cycle, the channel goes to `CH_WFINE` instead.

Top module: `interp_tdc_ctrl`

## Requirements
- R1: START and STOP each pass through a two-flop synchronizer and a rising-edge detector. A STOP raised k clock periods after START, with the same phase, yields a coarse count of exactly k.
- R2: A non-overflow result code equals coarse × 1000 + start fine − stop fine, computed signed. The code is clamped to 0 when negative and to 16000 when above 16000. Fine codes are 10-bit values from 0 to 999.
- R3: STOPs with a coarse count of 16 or less give a valid code. A channel with no STOP by the 16th edge presents a result with `res_ovr` high and code 0 when the window closes.
- R4: A channel keeps only its first STOP after a START. Later STOPs are ignored while it waits, while it holds a result, and after the result has been read, until the next START.
- R5: A channel raises `res_valid` for a captured STOP only after both its STOP fine strobe and the START fine strobe have been received.
- R6: `res_valid` and the code stay unchanged until `res_ready` is high. The result is consumed in the cycle where both are high, and the channel then goes idle.
- R7: A new START drops any unread result, re-arms every channel and takes a fresh START fine code.
- R8: Channels are independent. Each channel has its own STOP input, its own coarse capture and its own handshake.
- R9: After reset, no channel presents a result.
- R10: STOPs that arrive before the first START after reset produce no result.
- R11: A STOP detected in the same cycle as START is captured with a coarse count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_in | input | 1 | Asynchronous shared START pulse |
| stop_in | input | N_CH | Asynchronous STOP pulse, one per channel |
| start_fine_vld | input | 1 | Strobe for the START interpolator code |
| start_fine_code | input | FINE_W | START-to-edge fine code |
| stop_fine_vld | input | N_CH | Strobe for each STOP interpolator code |
| stop_fine_code | input | N_CH*FINE_W | STOP-to-edge fine codes; channel c is in slice c |
| res_ready | input | N_CH | Consumer ready, one per channel |
| res_valid | output | N_CH | Result present, one per channel |
| res_code | output | N_CH*CODE_W | Linear time code; channel c is in slice c |
| res_ovr | output | N_CH | Result marks an out-of-range STOP |

## Verification
The assertions assume well-formed inputs:

- START and STOP pulses stay high, and then low, for at least two clock periods.
- Fine codes are below 1000.
- Each fine strobe fires once per event, no earlier than the cycle after that event's synchronized detection.

The stimulus keeps every pulse high for three periods. It fires every fine strobe four periods after the event it belongs to, with a few deliberately later to exercise the gating. All pulses are launched two time units after a clock edge, so START and STOP share the same phase and the expected coarse count is the launch distance in periods.

// File: rtl/itdc_pkg.sv
package itdc_pkg;

    typedef enum logic [1:0] {
        WIN_IDLE,
        WIN_OPEN,
        WIN_SHUT
    } win_state_t;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_ARMED,
        CH_WFINE,
        CH_HOLD
    } ch_state_t;

    // Linear code from coarse edges and the two interpolator codes, clamped
    function automatic int lin_code(input int coarse, input int fs, input int fp,
                                    input int steps, input int full);
        int v;
        v = coarse * steps + fs - fp;
        if (v < 0)
            v = 0;
        else if (v > full)
            v = full;
        return v;
    endfunction

endpackage

// File: rtl/itdc_sync.sv
module itdc_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] rise
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;
    logic [W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= async_in;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    assign rise = sync_q & ~last_q;

endmodule

// File: rtl/itdc_window.sv
module itdc_window
    import itdc_pkg::*;
#(
    parameter int RANGE_EDGES = 16,
    parameter int FINE_STEPS  = 1000,
    parameter int CNT_W       = 5,
    parameter int FINE_W      = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              fine_vld,
    input  logic [FINE_W-1:0] fine_code,
    output logic [CNT_W-1:0]  win_cnt,
    output logic              expire,
    output logic              sfine_ok,
    output logic [FINE_W-1:0] sfine
);
    win_state_t        st_q, st_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              at_end;
    logic              sfine_ok_q;
    logic [FINE_W-1:0] sfine_q;

    assign at_end = (cnt_q == CNT_W'(RANGE_EDGES));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WIN_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (start_evt) begin
            st_d = WIN_OPEN;
        end else begin
            unique case (st_q)
                WIN_IDLE: st_d = WIN_IDLE;
                WIN_OPEN: if (at_end) st_d = WIN_SHUT;
                WIN_SHUT: st_d = WIN_SHUT;
                default:  st_d = WIN_IDLE;
            endcase
        end
    end

    // coarse edge counter and START fine latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q      <= '0;
            sfine_ok_q <= 1'b0;
            sfine_q    <= '0;
        end else if (start_evt) begin
            cnt_q      <= CNT_W'(1);
            sfine_ok_q <= 1'b0;
        end else begin
            if (st_q == WIN_OPEN && !at_end)
                cnt_q <= cnt_q + CNT_W'(1);
            if (st_q != WIN_IDLE && fine_vld && !sfine_ok_q) begin
                sfine_q    <= fine_code;
                sfine_ok_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        win_cnt  = cnt_q;
        expire   = (st_q == WIN_OPEN) && at_end && !start_evt;
        sfine_ok = sfine_ok_q;
        sfine    = sfine_q;
    end

    // R3
    win_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(RANGE_EDGES));

    // R1
    start_arms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (st_q == WIN_OPEN) && (cnt_q == CNT_W'(1)));

    // R3
    shut_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WIN_OPEN) && at_end && !start_evt |=> st_q == WIN_SHUT);

    // R2
    fine_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fine_vld |-> fine_code < FINE_W'(FINE_STEPS));

endmodule

// File: rtl/itdc_chan.sv
module itdc_chan
    import itdc_pkg::*;
#(
    parameter int FINE_STEPS = 1000,
    parameter int FULL       = 16000,
    parameter int CNT_W      = 5,
    parameter int FINE_W     = 10,
    parameter int CODE_W     = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic              expire,
    input  logic [CNT_W-1:0]  win_cnt,
    input  logic              sfine_ok,
    input  logic [FINE_W-1:0] sfine,
    input  logic              fine_vld,
    input  logic [FINE_W-1:0] fine_code,
    input  logic              res_ready,
    output logic              res_valid,
    output logic [CODE_W-1:0] res_code,
    output logic              res_ovr
);
    ch_state_t         st_q, st_d;
    logic [CNT_W-1:0]  coarse_q;
    logic [FINE_W-1:0] fine_q;
    logic              got_fine_q;
    logic              ovr_q;
    logic [CODE_W-1:0] code_calc;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CH_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        if (start_evt) begin
            st_d = stop_evt ? CH_WFINE : CH_ARMED;
        end else begin
            unique case (st_q)
                CH_IDLE:  st_d = CH_IDLE;
                CH_ARMED: begin
                    if (stop_evt)    st_d = CH_WFINE;
                    else if (expire) st_d = CH_HOLD;
                end
                CH_WFINE: if (got_fine_q && sfine_ok) st_d = CH_HOLD;
                CH_HOLD:  if (res_ready) st_d = CH_IDLE;
                default:  st_d = CH_IDLE;
            endcase
        end
    end

    // capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            coarse_q   <= '0;
            fine_q     <= '0;
            got_fine_q <= 1'b0;
            ovr_q      <= 1'b0;
        end else if (start_evt) begin
            coarse_q   <= '0;
            got_fine_q <= 1'b0;
            ovr_q      <= 1'b0;
        end else begin
            if (st_q == CH_ARMED && stop_evt)
                coarse_q <= win_cnt;
            if (st_q == CH_ARMED && !stop_evt && expire)
                ovr_q <= 1'b1;
            if (st_q == CH_WFINE && fine_vld && !got_fine_q) begin
                fine_q     <= fine_code;
                got_fine_q <= 1'b1;
            end
        end
    end

    assign code_calc = CODE_W'(lin_code(int'(coarse_q), int'(sfine), int'(fine_q),
                                        FINE_STEPS, FULL));

    // outputs
    always_comb begin
        res_valid = (st_q == CH_HOLD);
        res_ovr   = res_valid && ovr_q;
        res_code  = (res_valid && !ovr_q) ? code_calc : '0;
    end

    // R6
    hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ready && !start_evt |=> res_valid && $stable(res_code));

    // R3
    ovr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_ovr |-> res_code == '0);

    // R2
    code_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> res_code <= CODE_W'(FULL));

    // R7
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> !res_valid);

    // R5
    fine_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid && !res_ovr |-> got_fine_q && sfine_ok);

endmodule

// File: rtl/interp_tdc_ctrl.sv
module interp_tdc_ctrl #(
    parameter  int N_CH        = 4,
    parameter  int FINE_STEPS  = 1000,
    parameter  int RANGE_EDGES = 16,
    localparam int FULL        = RANGE_EDGES * FINE_STEPS,
    localparam int FINE_W      = $clog2(FINE_STEPS),
    localparam int CODE_W      = $clog2(FULL + 1),
    localparam int CNT_W       = $clog2(RANGE_EDGES + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_in,
    input  logic [N_CH-1:0]          stop_in,
    input  logic                     start_fine_vld,
    input  logic [FINE_W-1:0]        start_fine_code,
    input  logic [N_CH-1:0]          stop_fine_vld,
    input  logic [N_CH*FINE_W-1:0]   stop_fine_code,
    input  logic [N_CH-1:0]          res_ready,
    output logic [N_CH-1:0]          res_valid,
    output logic [N_CH*CODE_W-1:0]   res_code,
    output logic [N_CH-1:0]          res_ovr
);
    logic              start_evt;
    logic [N_CH-1:0]   stop_evt;
    logic [CNT_W-1:0]  win_cnt;
    logic              expire;
    logic              sfine_ok;
    logic [FINE_W-1:0] sfine;

    itdc_sync #(.W(1)) u_start_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (start_in),
        .rise     (start_evt)
    );

    itdc_sync #(.W(N_CH)) u_stop_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (stop_in),
        .rise     (stop_evt)
    );

    itdc_window #(
        .RANGE_EDGES (RANGE_EDGES),
        .FINE_STEPS  (FINE_STEPS),
        .CNT_W       (CNT_W),
        .FINE_W      (FINE_W)
    ) u_window (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .fine_vld  (start_fine_vld),
        .fine_code (start_fine_code),
        .win_cnt   (win_cnt),
        .expire    (expire),
        .sfine_ok  (sfine_ok),
        .sfine     (sfine)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_chan
        itdc_chan #(
            .FINE_STEPS (FINE_STEPS),
            .FULL       (FULL),
            .CNT_W      (CNT_W),
            .FINE_W     (FINE_W),
            .CODE_W     (CODE_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .start_evt (start_evt),
            .stop_evt  (stop_evt[c]),
            .expire    (expire),
            .win_cnt   (win_cnt),
            .sfine_ok  (sfine_ok),
            .sfine     (sfine),
            .fine_vld  (stop_fine_vld[c]),
            .fine_code (stop_fine_code[c*FINE_W +: FINE_W]),
            .res_ready (res_ready[c]),
            .res_valid (res_valid[c]),
            .res_code  (res_code[c*CODE_W +: CODE_W]),
            .res_ovr   (res_ovr[c])
        );
    end

endmodule

// File: tb/sim_interp_tdc_ctrl.sv
module sim_interp_tdc_ctrl;
    localparam int CLK_P = 10;
    localparam int N     = 4;
    localparam int FW    = 10;
    localparam int CW    = 14;
    localparam int STEPS = 1000;
    localparam int FULL  = 16000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start_in = 1'b0;
    logic [N-1:0]    stop_in = '0;
    logic            start_fine_vld = 1'b0;
    logic [FW-1:0]   start_fine_code = '0;
    logic [N-1:0]    stop_fine_vld = '0;
    logic [N*FW-1:0] stop_fine_code = '0;
    logic [N-1:0]    res_ready = '1;
    logic [N-1:0]    res_valid;
    logic [N*CW-1:0] res_code;
    logic [N-1:0]    res_ovr;

    always #(CLK_P/2) clk = ~clk;

    interp_tdc_ctrl #(.N_CH(N), .FINE_STEPS(STEPS), .RANGE_EDGES(16)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_in        (start_in),
        .stop_in         (stop_in),
        .start_fine_vld  (start_fine_vld),
        .start_fine_code (start_fine_code),
        .stop_fine_vld   (stop_fine_vld),
        .stop_fine_code  (stop_fine_code),
        .res_ready       (res_ready),
        .res_valid       (res_valid),
        .res_code        (res_code),
        .res_ovr         (res_ovr)
    );

    typedef struct packed {
        logic [7:0]  ch;
        logic [15:0] code;
        logic        ovr;
        logic [3:0]  req;
    } exp_t;

    exp_t sb[$];
    int   n_chk = 0;
    int   n_err = 0;
    bit   done  = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_code(input int k, input int fs, input int fp);
        int v;
        v = k * STEPS + fs - fp;
        if (v < 0) v = 0;
        if (v > FULL) v = FULL;
        return v;
    endfunction

    task automatic push(input int ch, input int code, input bit ovr, input int req);
        exp_t e;
        e.ch = 8'(ch); e.code = 16'(code); e.ovr = ovr; e.req = 4'(req);
        sb.push_back(e);
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic pulse_start(input int fs, input int fdly);
        start_in = 1'b1;
        step(3);
        start_in = 1'b0;
        step(fdly - 3);
        start_fine_code = FW'(fs);
        start_fine_vld  = 1'b1;
        step(1);
        start_fine_vld  = 1'b0;
    endtask

    task automatic pulse_stop(input int ch, input int k, input int fp, input int fdly);
        if (k > 0) step(k);
        stop_in[ch] = 1'b1;
        step(3);
        stop_in[ch] = 1'b0;
        step(fdly - 3);
        stop_fine_code[ch*FW +: FW] = FW'(fp);
        stop_fine_vld[ch] = 1'b1;
        step(1);
        stop_fine_vld[ch] = 1'b0;
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        int   got;
        if (rst_n) begin
            for (int c = 0; c < N; c++) begin
                if (res_valid[c] && res_ready[c]) begin
                    got = int'(res_code[c*CW +: CW]);
                    n_chk++;
                    if (sb.size() == 0) begin
                        n_err++;
                        $display("FAIL R4 R10 unexpected result ch%0d actual=%0d expected=none", c, got);
                    end else begin
                        e = sb.pop_front();
                        if (int'(e.ch) != c || int'(e.code) != got || e.ovr != res_ovr[c]) begin
                            n_err++;
                            $display("FAIL R%0d ch actual=%0d expected=%0d code actual=%0d expected=%0d ovr actual=%0d expected=%0d",
                                     e.req, c, e.ch, got, e.code, res_ovr[c], e.ovr);
                        end
                    end
                end
            end
        end
    end

    initial begin
        #(CLK_P * 100000);
        if (!done) begin
            n_err++;
            $display("FAIL R6 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(1);
        // R9 reset state
        chk(res_valid == '0, "R9 valid after reset", int'(res_valid), 0);
        chk(res_ovr == '0, "R9 ovr after reset", int'(res_ovr), 0);

        // R10 STOP before any START is ignored
        pulse_stop(1, 0, 300, 4);
        step(10);
        chk(res_valid == '0, "R10 stop without start", int'(res_valid), 0);

        // R1 R2 R8 four channels, distinct coarse counts
        push(0, exp_code(3, 400, 250), 1'b0, 1);
        push(3, exp_code(5, 400, 999), 1'b0, 2);
        push(1, exp_code(7, 400, 900), 1'b0, 8);
        push(2, exp_code(12, 400, 0), 1'b0, 1);
        fork
            pulse_start(400, 4);
            pulse_stop(0, 3, 250, 4);
            pulse_stop(1, 7, 900, 4);
            pulse_stop(2, 12, 0, 4);
            pulse_stop(3, 5, 999, 4);
        join
        step(10);

        // R3 range boundary: coarse 16 valid, 17 and none overflow; R2 top clamp
        push(1, 0, 1'b1, 3);
        push(2, 0, 1'b1, 3);
        push(0, FULL, 1'b0, 3);
        push(3, exp_code(16, 900, 100), 1'b0, 2);
        fork
            pulse_start(900, 4);
            pulse_stop(0, 16, 900, 4);
            pulse_stop(1, 17, 0, 4);
            pulse_stop(3, 16, 100, 4);
        join
        step(15);

        // R11 same-cycle START and STOP, R2 negative clamp
        push(0, exp_code(0, 700, 200), 1'b0, 11);
        push(1, 0, 1'b0, 2);
        push(2, 0, 1'b1, 3);
        push(3, 0, 1'b1, 3);
        fork
            pulse_start(700, 4);
            pulse_stop(0, 0, 200, 4);
            pulse_stop(1, 0, 950, 4);
        join
        step(20);

        // R4 only first STOP counts, later STOPs ignored also after read
        push(2, exp_code(2, 300, 100), 1'b0, 4);
        push(0, 0, 1'b1, 3);
        push(1, 0, 1'b1, 3);
        push(3, 0, 1'b1, 3);
        fork
            pulse_start(300, 4);
            pulse_stop(2, 2, 100, 4);
            pulse_stop(2, 8, 500, 4);
            pulse_stop(2, 14, 700, 4);
        join
        step(15);

        // R5 fine gating and R6 hold under back-pressure
        push(2, 0, 1'b1, 3);
        push(3, 0, 1'b1, 3);
        push(1, exp_code(3, 123, 0), 1'b0, 5);
        push(0, exp_code(2, 123, 23), 1'b0, 6);
        res_ready[0] = 1'b0;
        fork
            pulse_start(123, 20);
            pulse_stop(0, 2, 23, 4);
            pulse_stop(1, 3, 0, 12);
        join_none
        step(12);
        chk(res_valid[0] == 1'b0, "R5 ch0 waits for START fine", int'(res_valid[0]), 0);
        chk(res_valid[1] == 1'b0, "R5 ch1 waits for STOP fine", int'(res_valid[1]), 0);
        step(13);
        chk(res_valid[0] == 1'b1, "R5 ch0 valid after both fines", int'(res_valid[0]), 1);
        chk(int'(res_code[0 +: CW]) == 2100, "R2 ch0 code", int'(res_code[0 +: CW]), 2100);
        step(5);
        chk(res_valid[0] == 1'b1, "R6 valid held", int'(res_valid[0]), 1);
        chk(int'(res_code[0 +: CW]) == 2100, "R6 code stable", int'(res_code[0 +: CW]), 2100);
        res_ready[0] = 1'b1;
        wait fork;
        step(5);
        chk(res_valid[0] == 1'b0, "R6 idle after transfer", int'(res_valid[0]), 0);

        // R7 new START drops unread result and takes fresh START fine
        res_ready[3] = 1'b0;
        fork
            pulse_start(200, 4);
            pulse_stop(3, 3, 50, 4);
        join
        step(4);
        chk(res_valid[3] == 1'b1, "R6 unread result pending", int'(res_valid[3]), 1);
        push(3, exp_code(5, 600, 100), 1'b0, 7);
        push(0, 0, 1'b1, 3);
        push(1, 0, 1'b1, 3);
        push(2, 0, 1'b1, 3);
        fork
            pulse_start(600, 4);
            pulse_stop(3, 5, 100, 4);
        join_none
        step(4);
        chk(res_valid[3] == 1'b0, "R7 result dropped on restart", int'(res_valid[3]), 0);
        res_ready[3] = 1'b1;
        wait fork;
        step(25);

        // R8 every expected result seen, none left
        chk(sb.size() == 0, "R8 scoreboard drained", sb.size(), 0);
        done = 1'b1;
        summary();
        $finish;
    end

endmodule